// File: doc/BRIEF.md
# Precise Frequency Accuracy Monitor

This block decides whether a reference clock runs close enough to its nominal rate to be used for synchronization. It counts reference edge strobes across a long gate timed by the local oscillator, which is the block's own system clock. It then compares the count with a programmed expected value. The gate runs back to back, so a new measurement begins in the cycle after the previous one ends.

The absolute count error is judged against two limits. A reject limit sets the failure flag. A smaller accept limit clears it. An error that falls between the two leaves the flag as it was, so a reference sitting on the border of the acceptance range does not flap. A single-cycle or coarse frequency failure reported from upstream throws away the gate in progress and starts a fresh one, because a count taken across such an event cannot be trusted. Edge detection and clock domain crossing happen before this block, so `ref_edge` is a one-cycle strobe that is already synchronous to `clk`.

Top module: `freq_acc_mon`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `pfm_fail` is 1 and `meas_count` is 0.
- R2: A gate spans exactly `gate_len` clock cycles. At the clock edge that closes the gate's last cycle, `meas_count` takes the number of cycles within the gate in which `ref_edge` was 1. At every other edge `meas_count` keeps its value.
- R3: Gates run back to back. The first gate begins with the first cycle after reset is released, and each later gate begins in the cycle after the previous gate ends, whatever the pattern of strobes.
- R4: A cycle in which `scm_fail` or `cfm_fail` is 1 aborts the current gate. The count and the strobe in that cycle are discarded, a new gate starts in the next cycle, and `pfm_fail` and `meas_count` keep their values.
- R5: At the end of a completed gate, `pfm_fail` becomes 1 when |count − `exp_count`| is strictly greater than `reject_lim`. An error equal to `reject_lim` does not set it.
- R6: At the end of a completed gate, `pfm_fail` becomes 0 when |count − `exp_count`| is at or below `accept_lim`.
- R7: At the end of a completed gate whose error is above `accept_lim` and at or below `reject_lim`, `pfm_fail` keeps its previous value, whether that value is 0 or 1.
- R8: After reset, `pfm_fail` stays 1 until the first gate that completes without being aborted.
- R9: The edge count saturates at its all-ones value (2^CNT_W − 1) and does not wrap.
- R10: The error is symmetric. A count below `exp_count` by some amount is judged the same as a count above it by that same amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock; the measurement time base |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_edge | input | 1 | One-cycle strobe for each reference edge |
| scm_fail | input | 1 | Single-cycle monitor failure pulse; aborts the gate |
| cfm_fail | input | 1 | Coarse frequency monitor failure pulse; aborts the gate |
| gate_len | input | GATE_W | Gate length in clock cycles (at least 2) |
| exp_count | input | CNT_W | Expected strobe count per gate |
| accept_lim | input | CNT_W | Largest error that clears the failure flag |
| reject_lim | input | CNT_W | Error that must be exceeded to set the failure flag |
| pfm_fail | output | 1 | Frequency accuracy failure flag |
| meas_count | output | CNT_W | Strobe count of the last completed gate |

## Verification
Both outputs change at the same clock edge: the one that samples the gate's last cycle, or the cycle carrying the abort pulse. No result is due later than one edge after the driving cycle. The driver records the cycle number of each gate's final beat and queues the expected `pfm_fail` and `meas_count` with a due cycle one greater. The monitor compares them at the falling edge of exactly that cycle and flags any entry that comes due late. For aborted gates, the queued entry holds the unchanged values, so the discard is observed at the ports in the cycle it takes effect.

// File: rtl/fam_pkg.sv
package fam_pkg;

   // Decision taken by the hysteresis compare at a gate boundary
   typedef enum logic [1:0] {
      VERD_HOLD = 2'd0,
      VERD_SET  = 2'd1,
      VERD_CLR  = 2'd2
   } fam_verdict_e;

endpackage

// File: rtl/fam_gate_timer.sv
module fam_gate_timer #(
   parameter int GATE_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic [GATE_W-1:0] gate_len,
   output logic              gate_end,
   output logic [GATE_W-1:0] gate_pos
);

   localparam logic [GATE_W-1:0] ONE = GATE_W'(1);

   logic [GATE_W-1:0] pos_q;
   logic [GATE_W-1:0] last_pos;
   logic              at_last;

   assign last_pos = gate_len - ONE;
   assign at_last  = (pos_q >= last_pos);
   // An abort in the last cycle wins: that gate is discarded
   assign gate_end = at_last & ~restart;
   assign gate_pos = pos_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (restart || at_last) begin
         pos_q <= '0;
      end else begin
         pos_q <= pos_q + ONE;
      end
   end

endmodule

// File: rtl/fam_edge_counter.sv
module fam_edge_counter #(
   parameter int CNT_W    = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             gate_end,
   input  logic             ref_edge,
   output logic [CNT_W-1:0] acc,
   output logic [CNT_W-1:0] final_cnt,
   output logic [CNT_W-1:0] meas_q
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] acc_q;
   logic [CNT_W-1:0] meas_r;
   logic [CNT_W-1:0] acc_inc;

   generate
      if (SATURATE) begin : g_sat
         assign acc_inc = (acc_q == CNT_MAX) ? acc_q : acc_q + CNT_ONE;
      end else begin : g_wrap
         assign acc_inc = acc_q + CNT_ONE;
      end
   endgenerate

   // Count including this cycle's strobe
   assign final_cnt = ref_edge ? acc_inc : acc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q  <= '0;
         meas_r <= '0;
      end else if (restart) begin
         acc_q  <= '0;
      end else if (gate_end) begin
         acc_q  <= '0;
         meas_r <= final_cnt;
      end else begin
         acc_q  <= final_cnt;
      end
   end

   assign acc    = acc_q;
   assign meas_q = meas_r;

endmodule

// File: rtl/fam_hyst_cmp.sv
module fam_hyst_cmp
   import fam_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gate_end,
   input  logic [CNT_W-1:0] final_cnt,
   input  logic [CNT_W-1:0] exp_count,
   input  logic [CNT_W-1:0] accept_lim,
   input  logic [CNT_W-1:0] reject_lim,
   output logic             fail
);

   logic [CNT_W-1:0] err_mag;
   fam_verdict_e     verdict;
   logic             fail_q;

   assign err_mag = (final_cnt >= exp_count) ? (final_cnt - exp_count)
                                             : (exp_count - final_cnt);

   always_comb begin
      if (err_mag > reject_lim) begin
         verdict = VERD_SET;
      end else if (err_mag <= accept_lim) begin
         verdict = VERD_CLR;
      end else begin
         verdict = VERD_HOLD;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fail_q <= 1'b1;
      end else if (gate_end) begin
         case (verdict)
            VERD_SET: fail_q <= 1'b1;
            VERD_CLR: fail_q <= 1'b0;
            default:  fail_q <= fail_q;
         endcase
      end
   end

   assign fail = fail_q;

endmodule

// File: rtl/freq_acc_mon.sv
module freq_acc_mon #(
   parameter int GATE_W   = 32,
   parameter int CNT_W    = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_edge,
   input  logic              scm_fail,
   input  logic              cfm_fail,
   input  logic [GATE_W-1:0] gate_len,
   input  logic [CNT_W-1:0]  exp_count,
   input  logic [CNT_W-1:0]  accept_lim,
   input  logic [CNT_W-1:0]  reject_lim,
   output logic              pfm_fail,
   output logic [CNT_W-1:0]  meas_count
);

   generate
      if (GATE_W < 2 || GATE_W > 64) begin : g_bad_gate_w
         $error("freq_acc_mon: GATE_W must lie in 2..64");
      end
      if (CNT_W < 2 || CNT_W > 64) begin : g_bad_cnt_w
         $error("freq_acc_mon: CNT_W must lie in 2..64");
      end
   endgenerate

   logic              gate_restart;
   logic              gate_end;
   logic [GATE_W-1:0] gate_pos;
   logic [CNT_W-1:0]  edge_acc;
   logic [CNT_W-1:0]  edge_final;

   assign gate_restart = scm_fail | cfm_fail;

   fam_gate_timer #(.GATE_W(GATE_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (gate_restart),
      .gate_len (gate_len),
      .gate_end (gate_end),
      .gate_pos (gate_pos)
   );

   fam_edge_counter #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (gate_restart),
      .gate_end  (gate_end),
      .ref_edge  (ref_edge),
      .acc       (edge_acc),
      .final_cnt (edge_final),
      .meas_q    (meas_count)
   );

   fam_hyst_cmp #(.CNT_W(CNT_W)) u_cmp (
      .clk        (clk),
      .rst_n      (rst_n),
      .gate_end   (gate_end),
      .final_cnt  (edge_final),
      .exp_count  (exp_count),
      .accept_lim (accept_lim),
      .reject_lim (reject_lim),
      .fail       (pfm_fail)
   );

endmodule

// File: rtl/fam_chk.sv
module fam_chk #(
   parameter int GATE_W = 32,
   parameter int CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              restart,
   input logic              gate_end,
   input logic [GATE_W-1:0] gate_pos,
   input logic [CNT_W-1:0]  acc,
   input logic [CNT_W-1:0]  exp_count,
   input logic [CNT_W-1:0]  accept_lim,
   input logic [CNT_W-1:0]  reject_lim,
   input logic              pfm_fail,
   input logic [CNT_W-1:0]  meas_count
);

   logic [CNT_W-1:0] seen_err;
   logic             lims_steady;

   assign seen_err = (meas_count >= exp_count) ? (meas_count - exp_count)
                                               : (exp_count - meas_count);

   always_comb lims_steady = 1'b1;

   // R4
   restart_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (gate_pos == '0) && (acc == '0));

   // R4
   abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> $stable(pfm_fail) && $stable(meas_count));

   // R2
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_end |=> $stable(meas_count));

   // R7
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_end |=> $stable(pfm_fail));

   // R3
   back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gate_end |=> (gate_pos == '0));

   // R5
   reject_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gate_end |=> (!$stable(exp_count) || !$stable(reject_lim) ||
                    (seen_err <= reject_lim) || pfm_fail));

   // R6
   accept_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gate_end |=> (!$stable(exp_count) || !$stable(accept_lim) ||
                    !$stable(reject_lim) || (seen_err > reject_lim) ||
                    (seen_err > accept_lim) || !pfm_fail));

endmodule

bind freq_acc_mon fam_chk #(.GATE_W(GATE_W), .CNT_W(CNT_W)) u_fam_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .restart    (gate_restart),
   .gate_end   (gate_end),
   .gate_pos   (gate_pos),
   .acc        (edge_acc),
   .exp_count  (exp_count),
   .accept_lim (accept_lim),
   .reject_lim (reject_lim),
   .pfm_fail   (pfm_fail),
   .meas_count (meas_count)
);

// File: tb/freq_acc_mon_test.sv
module freq_acc_mon_test;

   localparam int GW = 16;
   localparam int CW = 8;
   localparam int CMAX = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ref_edge = 1'b0;
   logic          scm_fail = 1'b0;
   logic          cfm_fail = 1'b0;
   logic [GW-1:0] gate_len = GW'(100);
   logic [CW-1:0] exp_count = CW'(50);
   logic [CW-1:0] accept_lim = CW'(2);
   logic [CW-1:0] reject_lim = CW'(5);
   logic          pfm_fail;
   logic [CW-1:0] meas_count;

   freq_acc_mon #(.GATE_W(GW), .CNT_W(CW)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_edge   (ref_edge),
      .scm_fail   (scm_fail),
      .cfm_fail   (cfm_fail),
      .gate_len   (gate_len),
      .exp_count  (exp_count),
      .accept_lim (accept_lim),
      .reject_lim (reject_lim),
      .pfm_fail   (pfm_fail),
      .meas_count (meas_count)
   );

   always #4 clk = ~clk;

   typedef struct {
      int    due;
      bit    fail;
      int    count;
      string tag;
   } exp_item_t;

   exp_item_t sb_q[$];
   int  cyc = 0;
   int  n_chk = 0;
   int  n_bad = 0;
   bit  m_fail = 1'b1;
   int  m_count = 0;
   bit  finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string tag, input bit ok, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, expv, cyc);
      end
   endtask

   // Monitor: compare queued expectations in their due cycle
   always @(negedge clk) begin
      if (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
         exp_item_t it;
         it = sb_q.pop_front();
         check({it.tag, " due cycle"}, it.due == cyc, cyc, it.due);
         check({it.tag, " pfm_fail"}, pfm_fail == it.fail, int'(pfm_fail), int'(it.fail));
         check({it.tag, " meas_count"}, int'(meas_count) == it.count, int'(meas_count), it.count);
      end
   end

   // Driver: one gate per call; abort_at < 0 means no abort
   task automatic run_gate(input int n_edges, input bit spread, input int abort_at,
                           input bit use_cfm, input string tag);
      int len = int'(gate_len);
      int cnt = 0;
      for (int i = 0; i < len; i++) begin
         bit e = spread ? (i % 2 == 0) : (i < n_edges);
         bit ab = (i == abort_at);
         ref_edge = e;
         scm_fail = ab & ~use_cfm;
         cfm_fail = ab & use_cfm;
         if (ab) begin
            sb_q.push_back('{cyc + 1, m_fail, m_count, tag});
            @(negedge clk);
            return;
         end
         if (e && cnt < CMAX) cnt++;
         if (i == len - 1) begin
            int err = (cnt >= int'(exp_count)) ? cnt - int'(exp_count) : int'(exp_count) - cnt;
            if (err > int'(reject_lim)) m_fail = 1'b1;
            else if (err <= int'(accept_lim)) m_fail = 1'b0;
            m_count = cnt;
            sb_q.push_back('{cyc + 1, m_fail, m_count, tag});
         end
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      check("R1 reset pfm_fail", pfm_fail == 1'b1, int'(pfm_fail), 1);
      check("R1 reset meas_count", meas_count == '0, int'(meas_count), 0);
      rst_n = 1'b1;
      run_gate(50, 1'b0, 30, 1'b0, "R4 R8 scm abort keeps reset state");
      run_gate(50, 1'b0, -1, 1'b0, "R2 R3 R6 R8 exact count clears");
      run_gate(54, 1'b0, -1, 1'b0, "R7 in-band hold low");
      run_gate(56, 1'b0, -1, 1'b0, "R5 above reject sets");
      run_gate(46, 1'b0, -1, 1'b0, "R7 in-band hold high");
      run_gate(0, 1'b1, -1, 1'b0, "R2 R6 alternate strobes");
      run_gate(44, 1'b0, -1, 1'b0, "R10 below expected sets");
      run_gate(48, 1'b0, -1, 1'b0, "R6 R10 below within accept clears");
      run_gate(44, 1'b0, 99, 1'b1, "R4 cfm abort in last cycle");
      run_gate(55, 1'b0, 0, 1'b1, "R4 cfm abort in first cycle");
      run_gate(55, 1'b0, -1, 1'b0, "R5 error equal to reject holds");
      run_gate(43, 1'b0, -1, 1'b0, "R5 R10 error above reject sets");
      run_gate(52, 1'b0, -1, 1'b0, "R6 error equal to accept clears");
      gate_len = GW'(300);
      run_gate(300, 1'b0, -1, 1'b0, "R9 saturating count");
      ref_edge = 1'b0;
      scm_fail = 1'b0;
      cfm_fail = 1'b0;
      repeat (3) @(negedge clk);
      check("R2 scoreboard drained", sb_q.size() == 0, sb_q.size(), 0);
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule